// File: doc/BRIEF.md
# Three-Wide Rename Allocator with Drain Recovery

This block sits between instruction decode and the out-of-order core. Each cycle it accepts a group of up to three micro-ops and decides whether the group can enter the core. A group is admitted only when every reorder-buffer, reservation-station, load-buffer and store-buffer slot it needs is free. Admission is all or nothing. The reorder-buffer entry number given to each admitted micro-op also serves as its rename tag. An alias table records, for each architectural register, either the tag of its newest in-flight producer or a flag saying the committed value in the retirement register file is current.

Source operands are renamed in the same cycle they are presented. A source written by an older micro-op in the same group takes that micro-op's tag. Otherwise the source reads the alias table. That read is bypassed when the producer retires in the same cycle.

Branch recovery uses no checkpoints. A mispredict stops all renaming. Renaming stays stopped until the core reports that it has drained. At that point every alias entry is pointed back at the retirement register file in a single cycle.

Top module: `rename_alloc`

## Requirements
- R1: Every valid lane needs one reorder-buffer slot and one reservation-station slot. A lane whose memory-kind field has bit 0 set also needs a load-buffer slot, and bit 1 set needs a store-buffer slot. `grant` is high only if at least one lane is valid and all four free counts cover the group. When `grant` is low, the alias table and the tag counter are left unchanged.
- R2: Valid lanes receive consecutive tags starting at the internal tail counter, with lane 0 first. An invalid lane does not consume a tag. The tail advances by the number of valid lanes on a grant and wraps modulo the reorder-buffer depth. The tail is 0 after reset.
- R3: A source whose alias entry holds a tag is reported with `inrob`=1 and that tag. A source that maps to the retirement register file is reported with `inrob`=0 and tag 0.
- R4: A source of lane k that matches the destination of an older valid, writing lane j<k in the same group takes lane j's tag with `inrob`=1. The newest such lane wins. A lane's own destination never affects its own sources, and an invalid lane never forwards.
- R5: On a grant, each valid writing lane records its tag in the alias entry of its destination. When two lanes write the same register, the later lane's tag is kept.
- R6: From the cycle `mispredict` is high, `grant` stays low until the drain completes, whatever the free counts.
- R7: While recovering, the first cycle with `core_drained` high resets every alias entry to the retirement file at its closing edge. Grants may resume in the following cycle, and the tail is kept.
- R8: A retirement whose tag equals the current alias tag of its destination returns that entry to the retirement file. A retirement with a stale tag leaves the entry unchanged.
- R9: A source read in the same cycle as a matching retirement of that register reports `inrob`=0.
- R10: When a granted rename and a matching retirement hit the same register in one cycle, the rename wins.
- R11: Reset clears the recovery state, zeroes the tail and points every alias entry at the retirement file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_vld | input | LANES | Lane valid, lane 0 oldest |
| grp_dst_we | input | LANES | Lane writes a destination register |
| grp_dst | input | LANES x AW | Destination register per lane |
| grp_src_a | input | LANES x AW | First source register per lane |
| grp_src_b | input | LANES x AW | Second source register per lane |
| grp_mem | input | LANES x 2 | Bit 0 load, bit 1 store |
| rob_free | input | CNT_W | Free reorder-buffer slots |
| rs_free | input | CNT_W | Free reservation-station slots |
| ldb_free | input | CNT_W | Free load-buffer slots |
| stb_free | input | CNT_W | Free store-buffer slots |
| ret_vld | input | 1 | A micro-op retires this cycle |
| ret_dst | input | AW | Destination register of the retiring micro-op |
| ret_tag | input | TW | Tag of the retiring micro-op |
| mispredict | input | 1 | Branch misprediction detected |
| core_drained | input | 1 | Out-of-order core holds no in-flight work |
| grant | output | 1 | Whole group admitted this cycle |
| src_a_inrob | output | LANES | First source comes from the reorder buffer |
| src_a_tag | output | LANES x TW | First source tag |
| src_b_inrob | output | LANES | Second source comes from the reorder buffer |
| src_b_tag | output | LANES x TW | Second source tag |
| dst_tag | output | LANES x TW | Tag given to each lane |

## Verification
A corrupted alias entry shows up as a wrong source tag or flag on the first later read of that register. Such a read is combinational, so the error is visible in the same cycle the register is named. A wrong tail value appears at once on `dst_tag`, and it propagates as forwarded tags in that group. A stuck or missing recovery state shows as a grant in the cycle after a mispredict, or as stale tags read after the drain. The stimulus reads every register it has renamed, retired or reset, so each such fault reaches the ports within one or two cycles.

// File: rtl/ra_pkg.sv
package ra_pkg;
    localparam int DEF_LANES     = 3;
    localparam int DEF_NREG      = 8;
    localparam int DEF_ROB_DEPTH = 16;
    localparam int MEM_LD_BIT    = 0;
    localparam int MEM_ST_BIT    = 1;
    localparam int MEM_KIND_W    = 2;
endpackage

// File: rtl/ra_need_check.sv
module ra_need_check
    import ra_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int CNT_W = 5,
    localparam int NW   = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]                 vld,
    input  logic [LANES-1:0][MEM_KIND_W-1:0] mem,
    input  logic [CNT_W-1:0]                 rob_free,
    input  logic [CNT_W-1:0]                 rs_free,
    input  logic [CNT_W-1:0]                 ldb_free,
    input  logic [CNT_W-1:0]                 stb_free,
    output logic                             fits,
    output logic [NW-1:0]                    n_alloc
);
    int n_all;
    int n_ld;
    int n_st;

    always_comb begin
        n_all = 0;
        n_ld  = 0;
        n_st  = 0;
        for (int l = 0; l < LANES; l++) begin
            if (vld[l]) begin
                n_all = n_all + 1;
                if (mem[l][MEM_LD_BIT]) n_ld = n_ld + 1;
                if (mem[l][MEM_ST_BIT]) n_st = n_st + 1;
            end
        end
        fits    = (n_all <= int'(rob_free)) && (n_all <= int'(rs_free)) &&
                  (n_ld  <= int'(ldb_free)) && (n_st  <= int'(stb_free));
        n_alloc = NW'(n_all);
    end
endmodule

// File: rtl/ra_alias_table.sv
module ra_alias_table
    import ra_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int NREG  = DEF_NREG,
    parameter int TW    = 4,
    localparam int AW   = $clog2(NREG),
    localparam int NP   = 2 * LANES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic [LANES-1:0]            wr_en,
    input  logic [LANES-1:0][AW-1:0]    wr_reg,
    input  logic [LANES-1:0][TW-1:0]    wr_tag,
    input  logic                        ret_vld,
    input  logic [AW-1:0]               ret_dst,
    input  logic [TW-1:0]               ret_tag,
    input  logic [NP-1:0][AW-1:0]       rd_reg,
    output logic [NP-1:0]               rd_inrob,
    output logic [NP-1:0][TW-1:0]       rd_tag
);
    typedef struct packed {
        logic [NREG-1:0]         inrob;
        logic [NREG-1:0][TW-1:0] tag;
    } tbl_t;

    tbl_t tbl_q, tbl_d;
    logic ret_hit;
    logic ren_on_ret;

    always_comb begin
        tbl_d      = tbl_q;
        ret_hit    = ret_vld && tbl_q.inrob[ret_dst] && (tbl_q.tag[ret_dst] == ret_tag);
        ren_on_ret = 1'b0;
        if (clear) begin
            tbl_d.inrob = '0;
        end else begin
            if (ret_hit) tbl_d.inrob[ret_dst] = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                if (wr_en[l]) begin
                    tbl_d.inrob[wr_reg[l]] = 1'b1;
                    tbl_d.tag[wr_reg[l]]   = wr_tag[l];
                    if (wr_reg[l] == ret_dst) ren_on_ret = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar p = 0; p < NP; p++) begin : g_rd
        logic bypass;
        assign bypass      = ret_hit && (rd_reg[p] == ret_dst);
        assign rd_inrob[p] = tbl_q.inrob[rd_reg[p]] && !bypass;
        assign rd_tag[p]   = rd_inrob[p] ? tbl_q.tag[rd_reg[p]] : '0;
    end

    AST_RETIRE_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit && !ren_on_ret && !clear) |=> !tbl_q.inrob[$past(ret_dst)]); // R8
    AST_RENAME_BEATS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit && ren_on_ret && !clear) |=> tbl_q.inrob[$past(ret_dst)]); // R10
    AST_DRAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (tbl_q.inrob == '0)); // R7
endmodule

// File: rtl/ra_group_fwd.sv
module ra_group_fwd
    import ra_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int AW    = 3,
    parameter int TW    = 4,
    localparam int NP   = 2 * LANES
) (
    input  logic [LANES-1:0]          vld,
    input  logic [LANES-1:0]          we,
    input  logic [LANES-1:0][AW-1:0]  dst,
    input  logic [LANES-1:0][TW-1:0]  lane_tag,
    input  logic [NP-1:0][AW-1:0]     src,
    input  logic [NP-1:0]             tb_inrob,
    input  logic [NP-1:0][TW-1:0]     tb_tag,
    output logic [NP-1:0]             out_inrob,
    output logic [NP-1:0][TW-1:0]     out_tag
);
    for (genvar p = 0; p < NP; p++) begin : g_port
        localparam int LN = p % LANES;
        logic          sel_inrob;
        logic [TW-1:0] sel_tag;

        always_comb begin
            sel_inrob = tb_inrob[p];
            sel_tag   = tb_tag[p];
            for (int j = 0; j < LN; j++) begin
                if (vld[j] && we[j] && (dst[j] == src[p])) begin
                    sel_inrob = 1'b1;
                    sel_tag   = lane_tag[j];
                end
            end
        end

        assign out_inrob[p] = sel_inrob;
        assign out_tag[p]   = sel_tag;
    end
endmodule

// File: rtl/rename_alloc.sv
module rename_alloc
    import ra_pkg::*;
#(
    parameter int LANES     = DEF_LANES,
    parameter int NREG      = DEF_NREG,
    parameter int ROB_DEPTH = DEF_ROB_DEPTH,
    localparam int AW       = $clog2(NREG),
    localparam int TW       = $clog2(ROB_DEPTH),
    localparam int CNT_W    = $clog2(ROB_DEPTH + 1),
    localparam int NW       = $clog2(LANES + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [LANES-1:0]                 grp_vld,
    input  logic [LANES-1:0]                 grp_dst_we,
    input  logic [LANES-1:0][AW-1:0]         grp_dst,
    input  logic [LANES-1:0][AW-1:0]         grp_src_a,
    input  logic [LANES-1:0][AW-1:0]         grp_src_b,
    input  logic [LANES-1:0][MEM_KIND_W-1:0] grp_mem,
    input  logic [CNT_W-1:0]                 rob_free,
    input  logic [CNT_W-1:0]                 rs_free,
    input  logic [CNT_W-1:0]                 ldb_free,
    input  logic [CNT_W-1:0]                 stb_free,
    input  logic                             ret_vld,
    input  logic [AW-1:0]                    ret_dst,
    input  logic [TW-1:0]                    ret_tag,
    input  logic                             mispredict,
    input  logic                             core_drained,
    output logic                             grant,
    output logic [LANES-1:0]                 src_a_inrob,
    output logic [LANES-1:0][TW-1:0]         src_a_tag,
    output logic [LANES-1:0]                 src_b_inrob,
    output logic [LANES-1:0][TW-1:0]         src_b_tag,
    output logic [LANES-1:0][TW-1:0]         dst_tag
);
    localparam int NP = 2 * LANES;

    typedef struct packed {
        logic          recover;
        logic [TW-1:0] tail;
    } st_t;

    st_t st_q, st_d;

    logic                  fits;
    logic [NW-1:0]         n_alloc;
    logic [TW-1:0]         alloc_step;
    logic                  clear;
    logic [LANES-1:0]      wr_en;
    logic [NP-1:0][AW-1:0] rd_reg;
    logic [NP-1:0]         tb_inrob;
    logic [NP-1:0][TW-1:0] tb_tag;
    logic [NP-1:0]         fw_inrob;
    logic [NP-1:0][TW-1:0] fw_tag;

    ra_need_check #(.LANES(LANES), .CNT_W(CNT_W)) u_need (
        .vld      (grp_vld),
        .mem      (grp_mem),
        .rob_free (rob_free),
        .rs_free  (rs_free),
        .ldb_free (ldb_free),
        .stb_free (stb_free),
        .fits     (fits),
        .n_alloc  (n_alloc)
    );

    always_comb begin
        logic [TW-1:0] acc;
        grant = (|grp_vld) && fits && !st_q.recover && !mispredict;
        clear = st_q.recover && core_drained;
        wr_en = grant ? (grp_vld & grp_dst_we) : '0;
        acc   = st_q.tail;
        for (int l = 0; l < LANES; l++) begin
            dst_tag[l] = acc;
            acc        = acc + TW'(grp_vld[l]);
        end
        alloc_step = grant ? TW'(n_alloc) : '0;

        st_d      = st_q;
        st_d.tail = st_q.tail + alloc_step;
        if (mispredict)  st_d.recover = 1'b1;
        else if (clear)  st_d.recover = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_reg[l]          = grp_src_a[l];
        assign rd_reg[l + LANES]  = grp_src_b[l];
        assign src_a_inrob[l]     = fw_inrob[l];
        assign src_a_tag[l]       = fw_tag[l];
        assign src_b_inrob[l]     = fw_inrob[l + LANES];
        assign src_b_tag[l]       = fw_tag[l + LANES];
    end

    ra_alias_table #(.LANES(LANES), .NREG(NREG), .TW(TW)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .wr_en    (wr_en),
        .wr_reg   (grp_dst),
        .wr_tag   (dst_tag),
        .ret_vld  (ret_vld),
        .ret_dst  (ret_dst),
        .ret_tag  (ret_tag),
        .rd_reg   (rd_reg),
        .rd_inrob (tb_inrob),
        .rd_tag   (tb_tag)
    );

    ra_group_fwd #(.LANES(LANES), .AW(AW), .TW(TW)) u_fwd (
        .vld       (grp_vld),
        .we        (grp_dst_we),
        .dst       (grp_dst),
        .lane_tag  (dst_tag),
        .src       (rd_reg),
        .tb_inrob  (tb_inrob),
        .tb_tag    (tb_tag),
        .out_inrob (fw_inrob),
        .out_tag   (fw_tag)
    );

    AST_GRANT_NEEDS_UOP: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (|grp_vld)); // R1
    AST_GRANT_FITS_ROB: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ($countones(grp_vld) <= int'(rob_free))); // R1
    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (st_q.tail == TW'($past(st_q.tail) + TW'($countones($past(grp_vld)))))); // R2
    AST_NO_GRANT_AFTER_MISPRED: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> !grant); // R6
    AST_RECOVERY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.recover && core_drained && !mispredict) |=> !st_q.recover); // R7
endmodule

// File: tb/sim_rename_alloc.sv
module sim_rename_alloc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [2:0]      grp_vld, grp_dst_we;
    logic [2:0][2:0] grp_dst, grp_src_a, grp_src_b;
    logic [2:0][1:0] grp_mem;
    logic [4:0]      rob_free, rs_free, ldb_free, stb_free;
    logic            ret_vld;
    logic [2:0]      ret_dst;
    logic [3:0]      ret_tag;
    logic            mispredict, core_drained;
    logic            grant;
    logic [2:0]      src_a_inrob, src_b_inrob;
    logic [2:0][3:0] src_a_tag, src_b_tag, dst_tag;

    rename_alloc u0 (
        .clk(clk), .rst_n(rst_n), .grp_vld(grp_vld), .grp_dst_we(grp_dst_we),
        .grp_dst(grp_dst), .grp_src_a(grp_src_a), .grp_src_b(grp_src_b),
        .grp_mem(grp_mem), .rob_free(rob_free), .rs_free(rs_free),
        .ldb_free(ldb_free), .stb_free(stb_free), .ret_vld(ret_vld),
        .ret_dst(ret_dst), .ret_tag(ret_tag), .mispredict(mispredict),
        .core_drained(core_drained), .grant(grant), .src_a_inrob(src_a_inrob),
        .src_a_tag(src_a_tag), .src_b_inrob(src_b_inrob), .src_b_tag(src_b_tag),
        .dst_tag(dst_tag)
    );

    typedef struct packed {
        logic [2:0]  vld;
        logic [2:0]  we;
        logic [8:0]  dst;
        logic [8:0]  sa;
        logic [5:0]  mem;
        logic [4:0]  rob;
        logic [4:0]  rs;
        logic [4:0]  ld;
        logic [4:0]  st;
        logic        rv;
        logic [2:0]  rd;
        logic [3:0]  rt;
        logic        fl;
        logic        em;
        logic        eg;
        logic [2:0]  ef;
        logic [11:0] et;
        logic [3:0]  edt;
        logic [3:0]  rq;
    } vec_t;

    // Fields with three lanes are packed {lane2, lane1, lane0}.
    localparam vec_t VECS [13] = '{
        '{vld:3'b111, we:3'b111, dst:{3'd1,3'd2,3'd1}, sa:{3'd1,3'd1,3'd2}, mem:6'b0,
          rob:5'd16, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b0, em:1'b0,
          eg:1'b1, ef:3'b110, et:{4'd0,4'd0,4'd0}, edt:4'd0, rq:4'd4},
        '{vld:3'b111, we:3'b001, dst:{3'd0,3'd0,3'd3}, sa:{3'd3,3'd2,3'd1}, mem:6'b0,
          rob:5'd16, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b0, em:1'b0,
          eg:1'b1, ef:3'b111, et:{4'd3,4'd1,4'd2}, edt:4'd3, rq:4'd5},
        '{vld:3'b111, we:3'b001, dst:{3'd0,3'd0,3'd4}, sa:{3'd1,3'd5,3'd3}, mem:{2'b10,2'b01,2'b01},
          rob:5'd16, rs:5'd16, ld:5'd1, st:5'd16, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b0, em:1'b0,
          eg:1'b0, ef:3'b101, et:{4'd2,4'd0,4'd3}, edt:4'd6, rq:4'd1},
        '{vld:3'b111, we:3'b001, dst:{3'd0,3'd0,3'd4}, sa:{3'd1,3'd4,3'd4}, mem:{2'b10,2'b01,2'b01},
          rob:5'd16, rs:5'd16, ld:5'd2, st:5'd1, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b0, em:1'b0,
          eg:1'b1, ef:3'b110, et:{4'd2,4'd6,4'd0}, edt:4'd6, rq:4'd1},
        '{vld:3'b011, we:3'b000, dst:9'd0, sa:{3'd0,3'd2,3'd1}, mem:6'b0,
          rob:5'd16, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b1, rd:3'd1, rt:4'd2, fl:1'b0, em:1'b0,
          eg:1'b1, ef:3'b010, et:{4'd0,4'd1,4'd0}, edt:4'd9, rq:4'd9},
        '{vld:3'b011, we:3'b001, dst:{3'd0,3'd0,3'd2}, sa:{3'd0,3'd2,3'd1}, mem:6'b0,
          rob:5'd16, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b1, rd:3'd2, rt:4'd1, fl:1'b0, em:1'b0,
          eg:1'b1, ef:3'b010, et:{4'd0,4'd11,4'd0}, edt:4'd11, rq:4'd10},
        '{vld:3'b111, we:3'b000, dst:9'd0, sa:{3'd4,3'd3,3'd2}, mem:6'b0,
          rob:5'd3, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b1, rd:3'd3, rt:4'd3, fl:1'b0, em:1'b0,
          eg:1'b1, ef:3'b101, et:{4'd6,4'd0,4'd11}, edt:4'd13, rq:4'd9},
        '{vld:3'b111, we:3'b001, dst:{3'd0,3'd0,3'd5}, sa:{3'd3,3'd5,3'd0}, mem:6'b0,
          rob:5'd16, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b0, em:1'b0,
          eg:1'b1, ef:3'b010, et:{4'd0,4'd0,4'd0}, edt:4'd0, rq:4'd2},
        '{vld:3'b111, we:3'b000, dst:9'd0, sa:{3'd1,3'd4,3'd5}, mem:6'b0,
          rob:5'd2, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b0, em:1'b0,
          eg:1'b0, ef:3'b011, et:{4'd0,4'd6,4'd0}, edt:4'd3, rq:4'd1},
        '{vld:3'b111, we:3'b000, dst:9'd0, sa:{3'd2,3'd4,3'd5}, mem:6'b0,
          rob:5'd16, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b1, em:1'b0,
          eg:1'b0, ef:3'b111, et:{4'd11,4'd6,4'd0}, edt:4'd3, rq:4'd6},
        '{vld:3'b111, we:3'b000, dst:9'd0, sa:{3'd2,3'd4,3'd5}, mem:6'b0,
          rob:5'd16, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b0, em:1'b0,
          eg:1'b0, ef:3'b111, et:{4'd11,4'd6,4'd0}, edt:4'd3, rq:4'd6},
        '{vld:3'b111, we:3'b000, dst:9'd0, sa:{3'd2,3'd4,3'd5}, mem:6'b0,
          rob:5'd16, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b0, em:1'b1,
          eg:1'b0, ef:3'b111, et:{4'd11,4'd6,4'd0}, edt:4'd3, rq:4'd7},
        '{vld:3'b111, we:3'b001, dst:{3'd0,3'd0,3'd6}, sa:{3'd2,3'd4,3'd5}, mem:6'b0,
          rob:5'd16, rs:5'd16, ld:5'd16, st:5'd16, rv:1'b0, rd:3'd0, rt:4'd0, fl:1'b0, em:1'b0,
          eg:1'b1, ef:3'b000, et:{4'd0,4'd0,4'd0}, edt:4'd3, rq:4'd7}
    };

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    function automatic string rqname(input int n);
        case (n)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic idle();
        grp_vld = '0; grp_dst_we = '0; grp_dst = '0; grp_src_a = '0; grp_src_b = '0;
        grp_mem = '0; rob_free = 5'd16; rs_free = 5'd16; ldb_free = 5'd16; stb_free = 5'd16;
        ret_vld = 1'b0; ret_dst = '0; ret_tag = '0; mispredict = 1'b0; core_drained = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        idle();
        grp_src_a = {3'd1, 3'd1, 3'd1};
        repeat (2) @(negedge clk);
        #5;
        chk("R11", "reset src_a flags", int'(src_a_inrob), 0);
        chk("R11", "reset dst_tag lane0", int'(dst_tag[0]), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            grp_vld = VECS[i].vld; grp_dst_we = VECS[i].we; grp_dst = VECS[i].dst;
            grp_src_a = VECS[i].sa; grp_src_b = '0; grp_mem = VECS[i].mem;
            rob_free = VECS[i].rob; rs_free = VECS[i].rs;
            ldb_free = VECS[i].ld; stb_free = VECS[i].st;
            ret_vld = VECS[i].rv; ret_dst = VECS[i].rd; ret_tag = VECS[i].rt;
            mispredict = VECS[i].fl; core_drained = VECS[i].em;
            #5;
            chk(rqname(int'(VECS[i].rq)), $sformatf("v%0d grant", i), int'(grant), int'(VECS[i].eg));
            chk(rqname(int'(VECS[i].rq)), $sformatf("v%0d src_a flags", i),
                int'(src_a_inrob), int'(VECS[i].ef));
            chk("R3", $sformatf("v%0d src_a tags", i), int'(src_a_tag), int'(VECS[i].et));
            chk("R2", $sformatf("v%0d dst_tag lane0", i), int'(dst_tag[0]), int'(VECS[i].edt));
        end

        // Stale retirement of r6 (entry holds tag 3): no bypass, no revert.
        @(negedge clk);
        idle();
        ret_vld = 1'b1; ret_dst = 3'd6; ret_tag = 4'd9; grp_src_b[0] = 3'd6;
        #5;
        chk("R8", "stale retire read flag", int'(src_b_inrob[0]), 1);
        chk("R8", "stale retire read tag", int'(src_b_tag[0]), 3);
        chk("R1", "no valid lane grant", int'(grant), 0);
        @(negedge clk);
        ret_vld = 1'b0;
        #5;
        chk("R8", "after stale retire flag", int'(src_b_inrob[0]), 1);
        chk("R8", "after stale retire tag", int'(src_b_tag[0]), 3);

        // Matching retirement of r6: bypass, then revert.
        @(negedge clk);
        ret_vld = 1'b1; ret_tag = 4'd3;
        #5;
        chk("R9", "same-cycle retire bypass on src_b", int'(src_b_inrob[0]), 0);
        @(negedge clk);
        ret_vld = 1'b0;
        #5;
        chk("R8", "matching retire reverted entry", int'(src_b_inrob[0]), 0);

        // Lane gap: lanes 0 and 2 valid, invalid lane 1 also names r6.
        @(negedge clk);
        grp_vld = 3'b101; grp_dst_we = 3'b011; grp_dst = {3'd0, 3'd6, 3'd6};
        grp_src_a = {3'd6, 3'd0, 3'd0};
        #5;
        chk("R1", "gap group grant", int'(grant), 1);
        chk("R2", "gap lane2 dst_tag", int'(dst_tag[2]), 7);
        chk("R4", "invalid lane skipped, flag", int'(src_a_inrob[2]), 1);
        chk("R4", "invalid lane skipped, tag", int'(src_a_tag[2]), 6);

        // Reset after activity.
        @(negedge clk);
        idle();
        grp_vld = 3'b001; grp_src_a = {3'd0, 3'd0, 3'd6};
        #5;
        chk("R5", "r6 renamed to tag 6, flag", int'(src_a_inrob[0]), 1);
        chk("R5", "r6 renamed to tag 6, tag", int'(src_a_tag[0]), 6);
        rst_n = 1'b0;
        #2;
        chk("R11", "reset clears alias entry", int'(src_a_inrob[0]), 0);
        chk("R11", "reset zeroes tail", int'(dst_tag[0]), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mispredict = 1'b0;
        #5;
        chk("R11", "grant after reset", int'(grant), 1);

        finish_run();
    end
endmodule